// File: doc/BRIEF.md
# Two-Level Decoded SRAM Array

This block is a 32K x 8 static memory made of eight bit-sliced storage arrays. Each array holds 512 rows of 64 bits. A single row decoder turns the upper nine address bits into one row-enable line, and that line is shared by all eight arrays. Inside each array a column multiplexer uses the lower six address bits to pick one bit of the active row. Array k therefore supplies data bit k. Splitting the decode into a row step and a column step replaces a flat 32768-way decoder with a 512-way decoder plus eight 64-to-1 multiplexers.

Writes are synchronous. On a rising clock edge with chip select and write enable both high, the addressed bit of every slice takes its bit of the write bus. No other bit in the row changes. Reads are combinational from the address to the read bus. The read bus carries stored data only while chip select and output enable are high and write enable is low. In every other case it is held at zero. The storage has no reset, so its contents are undefined until a location has been written.

Top module: `sram_two_level`

## Requirements
- R1: A 15-bit address selects one of 32768 independent byte locations. Bits [14:6] name the row and bits [5:0] name the column. Locations that differ only in their row bits hold separate data.
- R2: The row decoder drives exactly one of its 512 row-enable lines, and the line that is driven is the one whose index equals address bits [14:6].
- R3: When chip_sel and wr_en are both 1 at a rising clock edge, the byte on wdata is stored at the location given by addr. A later read of that address returns it, with bit k of the byte coming from slice k.
- R4: A write changes only the addressed column bit in each slice. The other 63 bits of the same row keep their contents, so neighbouring addresses read back unchanged.
- R5: The read path has no register. With chip_sel=1, out_en=1 and wr_en=0, rdata shows the stored byte in the same cycle that addr is applied, and it stays steady while the address is held.
- R6: rdata is 0 whenever chip_sel=0, out_en=0 or wr_en=1.
- R7: When chip_sel is 0, a 1 on wr_en stores nothing, and the addressed location keeps its earlier contents.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Write clock, active on the rising edge |
| chip_sel | input | 1 | Chip select, active high; gates both reads and writes |
| out_en | input | 1 | Output enable, active high; gates the read bus |
| wr_en | input | 1 | Write enable, active high |
| addr | input | 15 | Byte address: row in [14:6], column in [5:0] |
| wdata | input | 8 | Write data; bit k goes to slice k |
| rdata | output | 8 | Read data; 0 when no read is active |

## Verification
Properties are checked on every cycle:
- the row-enable vector has exactly one line set, and that line matches the row field of the address;
- rdata is zero whenever no read is active;
- a read held at one address gives a steady value;
- a read that follows a write to the same address returns the byte just written.

Other behaviours need the bench's scenarios:
- bytes in neighbouring columns survive an overwrite;
- a write with chip select low has no effect;
- every one of the 512 rows keeps its own data;
- random traffic agrees with a flat byte-wide reference model.

// File: rtl/sram2l_pkg.sv
package sram2l_pkg;

  localparam int DEF_ROW_BITS = 9;
  localparam int DEF_COL_BITS = 6;
  localparam int DEF_LANES    = 8;

  typedef enum logic [1:0] {
    ACC_IDLE  = 2'd0,
    ACC_READ  = 2'd1,
    ACC_WRITE = 2'd2
  } access_e;

  // Classify the control inputs into one access kind.
  function automatic access_e access_kind(input logic cs, input logic oe, input logic we);
    if (!cs)     return ACC_IDLE;
    else if (we) return ACC_WRITE;
    else if (oe) return ACC_READ;
    else         return ACC_IDLE;
  endfunction

endpackage

// File: rtl/sram2l_row_decoder.sv
module sram2l_row_decoder #(
  parameter int ROW_BITS = 9,
  localparam int ROWS = 1 << ROW_BITS
) (
  input  logic [ROW_BITS-1:0] row_idx,
  output logic [ROWS-1:0]     row_en
);

  for (genvar r = 0; r < ROWS; r++) begin : g_line
    assign row_en[r] = (row_idx == ROW_BITS'(r));
  end

endmodule

// File: rtl/sram2l_col_mux.sv
module sram2l_col_mux #(
  parameter int COL_BITS = 6,
  localparam int COLS = 1 << COL_BITS
) (
  input  logic [COLS-1:0]     word_i,
  input  logic [COL_BITS-1:0] sel_i,
  output logic                bit_o
);

  // The select works as a binary tree: each level halves the candidates.
  logic [COLS-1:0] stage [COL_BITS+1];

  assign stage[0] = word_i;

  for (genvar l = 0; l < COL_BITS; l++) begin : g_lvl
    localparam int N = COLS >> (l + 1);
    for (genvar i = 0; i < COLS; i++) begin : g_node
      if (i < N) begin : g_used
        assign stage[l+1][i] = sel_i[l] ? stage[l][2*i+1] : stage[l][2*i];
      end else begin : g_pad
        assign stage[l+1][i] = 1'b0;
      end
    end
  end

  assign bit_o = stage[COL_BITS][0];

endmodule

// File: rtl/sram2l_slice.sv
module sram2l_slice #(
  parameter int ROW_BITS = 9,
  parameter int COL_BITS = 6,
  localparam int ROWS = 1 << ROW_BITS,
  localparam int COLS = 1 << COL_BITS
) (
  input  logic                clk,
  input  logic [ROWS-1:0]     row_en,
  input  logic [COL_BITS-1:0] col_sel,
  input  logic                wr,
  input  logic                din_bit,
  output logic                dout_bit
);

  logic [COLS-1:0] cells [ROWS];
  logic [COLS-1:0] row_word;

  // Write only the chosen bit of the enabled row.
  always_ff @(posedge clk) begin
    for (int r = 0; r < ROWS; r++) begin
      if (wr && row_en[r]) cells[r][col_sel] <= din_bit;
    end
  end

  // Wired-OR row read driven by the one-hot row enables.
  always_comb begin
    row_word = '0;
    for (int r = 0; r < ROWS; r++) begin
      row_word = row_word | ({COLS{row_en[r]}} & cells[r]);
    end
  end

  sram2l_col_mux #(.COL_BITS(COL_BITS)) u_mux (
    .word_i (row_word),
    .sel_i  (col_sel),
    .bit_o  (dout_bit)
  );

endmodule

// File: rtl/sram_two_level.sv
module sram_two_level
  import sram2l_pkg::*;
#(
  parameter int ROW_BITS = DEF_ROW_BITS,
  parameter int COL_BITS = DEF_COL_BITS,
  parameter int LANES    = DEF_LANES,
  localparam int ADDR_W = ROW_BITS + COL_BITS,
  localparam int ROWS   = 1 << ROW_BITS
) (
  input  logic              clk,
  input  logic              chip_sel,
  input  logic              out_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [LANES-1:0]  wdata,
  output logic [LANES-1:0]  rdata
);

  access_e             acc;
  logic                do_write;
  logic                do_read;
  logic [ROW_BITS-1:0] row_idx;
  logic [COL_BITS-1:0] col_idx;
  logic [ROWS-1:0]     row_en;
  logic [LANES-1:0]    lane_bits;

  assign acc      = access_kind(chip_sel, out_en, wr_en);
  assign do_write = (acc == ACC_WRITE);
  assign do_read  = (acc == ACC_READ);
  assign row_idx  = addr[ADDR_W-1:COL_BITS];
  assign col_idx  = addr[COL_BITS-1:0];

  sram2l_row_decoder #(.ROW_BITS(ROW_BITS)) u_rowdec (
    .row_idx (row_idx),
    .row_en  (row_en)
  );

  for (genvar k = 0; k < LANES; k++) begin : g_slice
    sram2l_slice #(.ROW_BITS(ROW_BITS), .COL_BITS(COL_BITS)) u_slice (
      .clk      (clk),
      .row_en   (row_en),
      .col_sel  (col_idx),
      .wr       (do_write),
      .din_bit  (wdata[k]),
      .dout_bit (lane_bits[k])
    );
  end

  assign rdata = do_read ? lane_bits : '0;

endmodule

// File: rtl/sram2l_checker.sv
module sram2l_checker #(
  parameter int ROW_BITS = 9,
  parameter int COL_BITS = 6,
  parameter int LANES    = 8,
  localparam int ADDR_W = ROW_BITS + COL_BITS,
  localparam int ROWS   = 1 << ROW_BITS
) (
  input logic              clk,
  input logic              chip_sel,
  input logic              out_en,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [LANES-1:0]  wdata,
  input logic [LANES-1:0]  rdata,
  input logic [ROWS-1:0]   row_en
);

  logic armed = 1'b0;
  always_ff @(posedge clk) armed <= 1'b1;

  logic rd_now;
  assign rd_now = chip_sel && out_en && !wr_en;

  // R2
  row_onehot_chk: assert property (@(posedge clk) disable iff (!armed)
    $countones(row_en) == 1);

  // R2
  row_match_chk: assert property (@(posedge clk) disable iff (!armed)
    row_en[addr[ADDR_W-1:COL_BITS]]);

  // R6
  idle_zero_chk: assert property (@(posedge clk) disable iff (!armed)
    !rd_now |-> rdata == '0);

  // R3
  wr_rd_chk: assert property (@(posedge clk) disable iff (!armed)
    (rd_now && $past(chip_sel && wr_en) && addr == $past(addr)) |-> rdata == $past(wdata));

  // R5
  hold_steady_chk: assert property (@(posedge clk) disable iff (!armed)
    (rd_now && $past(rd_now) && addr == $past(addr)) |-> $stable(rdata));

endmodule

bind sram_two_level sram2l_checker #(
  .ROW_BITS(ROW_BITS), .COL_BITS(COL_BITS), .LANES(LANES)
) u_chk (
  .clk      (clk),
  .chip_sel (chip_sel),
  .out_en   (out_en),
  .wr_en    (wr_en),
  .addr     (addr),
  .wdata    (wdata),
  .rdata    (rdata),
  .row_en   (row_en)
);

// File: tb/tb_sram_two_level.sv
`timescale 1ns/1ps
module tb_sram_two_level;

  logic        clk = 1'b0;
  logic        chip_sel = 1'b0;
  logic        out_en = 1'b0;
  logic        wr_en = 1'b0;
  logic [14:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;
  logic [7:0] ref_mem [int];

  always #2.5 clk = ~clk;

  sram_two_level dut (
    .clk(clk), .chip_sel(chip_sel), .out_en(out_en), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata)
  );

  // Each entry holds {address, data}.
  localparam logic [22:0] VEC [8] = '{
    {15'h0000, 8'h3C}, {15'h7FFF, 8'hC3}, {15'h003F, 8'h81}, {15'h0040, 8'h7E},
    {15'h7FC0, 8'h01}, {15'h2AAA, 8'hAA}, {15'h5555, 8'h55}, {15'h1000, 8'hF0}
  };

  task automatic chk(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [14:0] a, input logic [7:0] d);
    @(negedge clk);
    chip_sel = 1'b1; wr_en = 1'b1; out_en = 1'b0; addr = a; wdata = d;
    @(negedge clk);
    chip_sel = 1'b0; wr_en = 1'b0;
    ref_mem[int'(a)] = d;
  endtask

  task automatic do_read(input logic [14:0] a, input string req);
    @(negedge clk);
    chip_sel = 1'b1; out_en = 1'b1; wr_en = 1'b0; addr = a;
    #1;
    if (ref_mem.exists(int'(a))) chk(rdata === ref_mem[int'(a)], req, rdata, ref_mem[int'(a)]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // Idle state before any access: the read bus is zero (R6)
    #1;
    chk(rdata === 8'h00, "R6 idle", rdata, 8'h00);

    // Table walk: write every entry, then read all back (R1, R3)
    foreach (VEC[i]) do_write(VEC[i][22:8], VEC[i][7:0]);
    foreach (VEC[i]) do_read(VEC[i][22:8], "R3 table");

    // Same-cycle read: a change of address shows new data in the same cycle (R5)
    @(negedge clk);
    chip_sel = 1'b1; out_en = 1'b1; wr_en = 1'b0; addr = 15'h0000;
    #1 chk(rdata === 8'h3C, "R5 comb", rdata, 8'h3C);
    addr = 15'h7FFF;
    #1 chk(rdata === 8'hC3, "R5 comb", rdata, 8'hC3);

    // Neighbouring columns survive an overwrite (R4)
    do_write(15'h1233, 8'h00);
    do_write(15'h1234, 8'hFF);
    do_write(15'h1235, 8'h00);
    do_write(15'h1234, 8'h5A);
    do_read(15'h1233, "R4 left");
    do_read(15'h1235, "R4 right");
    do_read(15'h1234, "R4 target");

    // Read bus is gated by the controls (R6)
    do_write(15'h0100, 8'h11);
    @(negedge clk);
    chip_sel = 1'b0; out_en = 1'b1; wr_en = 1'b0; addr = 15'h0100;
    #1 chk(rdata === 8'h00, "R6 cs low", rdata, 8'h00);
    chip_sel = 1'b1; out_en = 1'b0;
    #1 chk(rdata === 8'h00, "R6 oe low", rdata, 8'h00);
    out_en = 1'b1; wr_en = 1'b1; wdata = 8'h11;
    #1 chk(rdata === 8'h00, "R6 we high", rdata, 8'h00);

    // A write enable with chip select low stores nothing (R7)
    @(negedge clk);
    chip_sel = 1'b0; wr_en = 1'b1; wdata = 8'hEE; addr = 15'h0100;
    @(negedge clk);
    wr_en = 1'b0;
    do_read(15'h0100, "R7 no write");

    // Every row holds its own data (R1, R2)
    for (int r = 0; r < 512; r++)
      do_write({r[8:0], 6'd13}, r[7:0] ^ (r[8] ? 8'hA5 : 8'h00));
    for (int r = 0; r < 512; r++)
      do_read({r[8:0], 6'd13}, "R2 row sweep");

    // Random traffic on a few crowded rows plus scattered addresses (R1, R3, R4)
    for (int i = 0; i < 1500; i++) begin
      logic [14:0] a;
      a = (i % 3 == 0) ? 15'($urandom) : {9'($urandom % 4), 6'($urandom)};
      do_write(a, 8'($urandom));
    end
    for (int i = 0; i < 1500; i++) begin
      logic [14:0] a;
      a = (i % 3 == 0) ? 15'($urandom) : {9'($urandom % 4), 6'($urandom)};
      do_read(a, "R1 random");
    end

    @(negedge clk);
    chip_sel = 1'b0; out_en = 1'b0;
    if (!done) begin
      done = 1'b1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule